// File: doc/BRIEF.md
# Punctured Parallel Concatenated Convolutional Encoder

This block turns a block of information bits into a turbo-style coded stream. Two identical recursive systematic convolutional encoders of memory 3 work on the same block. The first encoder sees the bits in arrival order. The second sees them in a permuted order, read from a second copy of the block buffer at address (P*j) mod K. For every information bit the block emits one symbol. The symbol carries the systematic bit and one parity bit from each encoder, and each parity bit has a keep flag that implements puncturing.

A block is loaded through a valid/ready bit interface. The first bit is marked with a start-of-block flag, and the rate select is captured with that bit. Once all K bits are stored, the input stalls while the block is encoded. The K data symbols are followed by six termination symbols: three that return the natural-order encoder to state zero, then three for the permuted-order encoder. Each termination symbol carries only its own encoder's parity bit. At rate 1/3 every parity bit is kept. At rate 1/2 the two parity streams are kept alternately.

Top module: `tc_ppc_encoder`

## Requirements
- R1: During and right after reset, out_valid is 0 and in_ready is 1.
- R2: The block accepts exactly K bits, then drops in_ready until every symbol of the block has been issued.
- R3: While idle, a bit offered without in_sob is ignored. A bit with in_sob always starts a new block at position 0, which also restarts a block that is partly loaded.
- R4: Data symbol j (j = 0..K-1, emitted in increasing j) has out_sys equal to input bit j of the block.
- R5: out_par1 of data symbol j is the parity of encoder A run on bits 0..j in natural order. Encoder A starts from state 0, with feedback 1+D+D^3 and parity 1+D^2+D^3. The feedback bit a = u^s1^s3 enters the register, and the parity is a^s2^s3.
- R6: out_par2 of data symbol j comes from an identical encoder B. Encoder B is fed input bit (P*j) mod K at step j and also starts from state 0.
- R7: After the data, three tail symbols with out_tail=1 come from encoder A. Each has out_sys equal to A's feedback bit, out_par1 kept and out_par2 not kept and reading 0. Then three tail symbols come from encoder B with the roles of the two parity fields swapped. Both encoders end in state 0.
- R8: With rate_half=0 at start of block, every data symbol has out_par1_keep=1 and out_par2_keep=1.
- R9: With rate_half=1 at start of block, data symbol j keeps only out_par1 when j is even and only out_par2 when j is odd. Tail symbols are never punctured.
- R10: The K+6 symbols of a block appear on consecutive cycles. The first has out_tail=0 and the last has out_tail=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bit offered |
| in_ready | output | 1 | Block can take an input bit |
| in_bit | input | 1 | Information bit |
| in_sob | input | 1 | Marks the first bit of a block |
| rate_half | input | 1 | 1: rate 1/2 puncturing, 0: rate 1/3; sampled with in_sob |
| out_valid | output | 1 | Output symbol valid |
| out_sys | output | 1 | Systematic or tail bit |
| out_par1 | output | 1 | Parity of the natural-order encoder |
| out_par1_keep | output | 1 | out_par1 is transmitted |
| out_par2 | output | 1 | Parity of the permuted-order encoder |
| out_par2_keep | output | 1 | out_par2 is transmitted |
| out_tail | output | 1 | Symbol is a termination symbol |

## Verification
The properties assume that in_sob is asserted only together with in_valid. They also assume that the rate select matters only on the start-of-block bit. The stimulus keeps to both rules. It drives inputs only on the falling edge and only when in_ready was already high, so no bit is offered to a stalled block except on purpose. The properties also assume that K and P are coprime, which the chosen defaults (16 and 5) satisfy, so the permuted read order visits each stored bit once per block.

// File: rtl/tc_pkg.sv
package tc_pkg;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_LOAD = 2'd1,
    CS_EMIT = 2'd2
  } ctl_state_e;

  typedef enum logic [1:0] {
    SK_DATA   = 2'd0,
    SK_TAIL_A = 2'd1,
    SK_TAIL_B = 2'd2
  } step_kind_e;

  localparam int unsigned CODE_MEM     = 3;
  // tap bit i weights register cell D^(i+1)
  localparam logic [CODE_MEM-1:0] FB_TAPS_DEF  = 3'b101;
  localparam logic [CODE_MEM-1:0] PAR_TAPS_DEF = 3'b110;

endpackage

// File: rtl/tc_rsc_enc.sv
module tc_rsc_enc #(
  parameter int unsigned         MEM      = 3,
  parameter logic [MEM-1:0]      FB_TAPS  = 3'b101,
  parameter logic [MEM-1:0]      PAR_TAPS = 3'b110
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           step,
  input  logic           term,
  input  logic           din,
  output logic           sys_o,
  output logic           par_o,
  output logic [MEM-1:0] state_o
);

  logic [MEM-1:0] st;
  logic           fb;
  logic           u;
  logic           a;

  always_comb begin
    fb    = ^(st & FB_TAPS);
    u     = term ? fb : din;      // tail: input cancels feedback
    a     = u ^ fb;
    par_o = a ^ (^(st & PAR_TAPS));
    sys_o = u;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st <= '0;
    end else if (step) begin
      st <= {st[MEM-2:0], a};
    end
  end

  assign state_o = st;

endmodule

// File: rtl/tc_bit_store.sv
module tc_bit_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/tc_perm_gen.sv
module tc_perm_gen #(
  parameter int unsigned BLK_LEN  = 16,
  parameter int unsigned PERM_MUL = 5,
  parameter int unsigned AW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] addr_o
);

  localparam int unsigned STRIDE = PERM_MUL % BLK_LEN;

  logic [AW-1:0] acc;
  logic [AW:0]   sum;
  logic [AW:0]   wrapped;

  always_comb begin
    sum     = {1'b0, acc} + (AW+1)'(STRIDE);
    wrapped = (sum >= (AW+1)'(BLK_LEN)) ? sum - (AW+1)'(BLK_LEN) : sum;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
    end else if (adv) begin
      acc <= wrapped[AW-1:0];
    end
  end

  assign addr_o = acc;

endmodule

// File: rtl/tc_ppc_encoder.sv
module tc_ppc_encoder
  import tc_pkg::*;
#(
  parameter int unsigned    BLK_LEN  = 16,
  parameter int unsigned    PERM_MUL = 5,
  parameter int unsigned    MEM      = CODE_MEM,
  parameter logic [MEM-1:0] FB_TAPS  = FB_TAPS_DEF,
  parameter logic [MEM-1:0] PAR_TAPS = PAR_TAPS_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_sob,
  input  logic rate_half,
  output logic out_valid,
  output logic out_sys,
  output logic out_par1,
  output logic out_par1_keep,
  output logic out_par2,
  output logic out_par2_keep,
  output logic out_tail
);

  localparam int unsigned AW    = (BLK_LEN > 2) ? $clog2(BLK_LEN) : 1;
  localparam int unsigned NSTEP = BLK_LEN + 2 * MEM;
  localparam int unsigned SW    = $clog2(NSTEP + 1);
  localparam logic [SW-1:0] END_DATA = SW'(BLK_LEN);
  localparam logic [SW-1:0] END_TLA  = SW'(BLK_LEN + MEM);
  localparam logic [SW-1:0] LAST_STP = SW'(NSTEP - 1);
  localparam logic [AW-1:0] LAST_WR  = AW'(BLK_LEN - 1);

  ctl_state_e  cs;
  logic [AW-1:0] wr_idx;
  logic [SW-1:0] step_idx;
  logic          rate_q;

  logic          acc_bit;
  logic          start;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          last_in;

  logic          issue;
  logic          is_data;
  step_kind_e    kind;
  logic [AW-1:0] perm_addr;
  logic [AW-1:0] raddr [2];
  logic          rd    [2];

  logic          s1_valid;
  step_kind_e    s1_kind;
  logic          s1_odd;
  logic          s1_last;
  logic          blk_done;

  logic          sys_a, par_a, sys_b, par_b;
  logic [MEM-1:0] st_a, st_b;

  // input side
  assign in_ready = (cs != CS_EMIT) && !s1_valid;
  assign acc_bit  = in_valid && in_ready;
  assign start    = acc_bit && in_sob;
  assign wr_en    = acc_bit && (in_sob || (cs == CS_LOAD));
  assign wr_addr  = in_sob ? '0 : wr_idx;
  assign last_in  = wr_en && (wr_addr == LAST_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs       <= CS_IDLE;
      wr_idx   <= '0;
      step_idx <= '0;
      rate_q   <= 1'b0;
    end else begin
      if (start) begin
        rate_q <= rate_half;
      end
      case (cs)
        CS_IDLE, CS_LOAD: begin
          if (wr_en) begin
            wr_idx <= wr_addr + AW'(1);
            if (last_in) begin
              cs       <= CS_EMIT;
              step_idx <= '0;
            end else begin
              cs <= CS_LOAD;
            end
          end
        end
        CS_EMIT: begin
          step_idx <= step_idx + SW'(1);
          if (step_idx == LAST_STP) begin
            cs <= CS_IDLE;
          end
        end
        default: cs <= CS_IDLE;
      endcase
    end
  end

  // issue side
  always_comb begin
    issue   = (cs == CS_EMIT);
    is_data = (step_idx < END_DATA);
    if (is_data) begin
      kind = SK_DATA;
    end else if (step_idx < END_TLA) begin
      kind = SK_TAIL_A;
    end else begin
      kind = SK_TAIL_B;
    end
  end

  tc_perm_gen #(
    .BLK_LEN (BLK_LEN),
    .PERM_MUL(PERM_MUL),
    .AW      (AW)
  ) u_perm (
    .clk   (clk),
    .rst   (rst),
    .clr   (start),
    .adv   (issue && is_data),
    .addr_o(perm_addr)
  );

  assign raddr[0] = step_idx[AW-1:0];
  assign raddr[1] = perm_addr;

  // two copies of the block, one per read order
  for (genvar g = 0; g < 2; g++) begin : g_store
    tc_bit_store #(
      .DEPTH(BLK_LEN),
      .AW   (AW)
    ) u_store (
      .clk  (clk),
      .we   (wr_en),
      .waddr(wr_addr),
      .wdata(in_bit),
      .re   (issue && is_data),
      .raddr(raddr[g]),
      .rdata(rd[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_kind  <= SK_DATA;
      s1_odd   <= 1'b0;
      s1_last  <= 1'b0;
    end else begin
      s1_valid <= issue;
      s1_kind  <= kind;
      s1_odd   <= step_idx[0];
      s1_last  <= issue && (step_idx == LAST_STP);
    end
  end

  // component encoders
  tc_rsc_enc #(
    .MEM     (MEM),
    .FB_TAPS (FB_TAPS),
    .PAR_TAPS(PAR_TAPS)
  ) u_enc_a (
    .clk    (clk),
    .rst    (rst),
    .clr    (start),
    .step   (s1_valid && (s1_kind != SK_TAIL_B)),
    .term   (s1_kind == SK_TAIL_A),
    .din    (rd[0]),
    .sys_o  (sys_a),
    .par_o  (par_a),
    .state_o(st_a)
  );

  tc_rsc_enc #(
    .MEM     (MEM),
    .FB_TAPS (FB_TAPS),
    .PAR_TAPS(PAR_TAPS)
  ) u_enc_b (
    .clk    (clk),
    .rst    (rst),
    .clr    (start),
    .step   (s1_valid && (s1_kind != SK_TAIL_A)),
    .term   (s1_kind == SK_TAIL_B),
    .din    (rd[1]),
    .sys_o  (sys_b),
    .par_o  (par_b),
    .state_o(st_b)
  );

  // puncturing and registered output
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_sys       <= 1'b0;
      out_par1      <= 1'b0;
      out_par1_keep <= 1'b0;
      out_par2      <= 1'b0;
      out_par2_keep <= 1'b0;
      out_tail      <= 1'b0;
      blk_done      <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      blk_done  <= s1_valid && s1_last;
      case (s1_kind)
        SK_DATA: begin
          out_sys       <= sys_a;
          out_par1      <= par_a;
          out_par2      <= par_b;
          out_par1_keep <= !rate_q || !s1_odd;
          out_par2_keep <= !rate_q || s1_odd;
          out_tail      <= 1'b0;
        end
        SK_TAIL_A: begin
          out_sys       <= sys_a;
          out_par1      <= par_a;
          out_par2      <= 1'b0;
          out_par1_keep <= 1'b1;
          out_par2_keep <= 1'b0;
          out_tail      <= 1'b1;
        end
        default: begin
          out_sys       <= sys_b;
          out_par1      <= 1'b0;
          out_par2      <= par_b;
          out_par1_keep <= 1'b0;
          out_par2_keep <= 1'b1;
          out_tail      <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/tc_ppc_encoder_chk.sv
module tc_ppc_encoder_chk #(
  parameter int unsigned MEM = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           out_valid,
  input logic           out_tail,
  input logic           out_par1_keep,
  input logic           out_par2_keep,
  input logic           rate_q,
  input logic           blk_done,
  input logic [MEM-1:0] st_a,
  input logic [MEM-1:0] st_b
);

  p_full_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !rate_q && !out_tail) |-> (out_par1_keep && out_par2_keep));

  p_half_alt_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && rate_q && !out_tail) |-> (out_par1_keep != out_par2_keep));

  p_tail_one_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_tail) |-> ($countones({out_par1_keep, out_par2_keep}) == 1));

  p_term_zero_r7: assert property (@(posedge clk) disable iff (rst)
    blk_done |-> ((st_a == '0) && (st_b == '0)));

  p_first_data_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> !out_tail);

  p_end_tail_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> $past(out_tail));

endmodule

bind tc_ppc_encoder tc_ppc_encoder_chk #(
  .MEM(MEM)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .out_valid    (out_valid),
  .out_tail     (out_tail),
  .out_par1_keep(out_par1_keep),
  .out_par2_keep(out_par2_keep),
  .rate_q       (rate_q),
  .blk_done     (blk_done),
  .st_a         (st_a),
  .st_b         (st_b)
);

// File: tb/test_tc_ppc_encoder.sv
module test_tc_ppc_encoder;

  localparam int CLK_PERIOD = 10;
  localparam int BK = 16;
  localparam int BP = 5;
  localparam int NS = BK + 6;
  localparam int NV = 6;
  // bit 16: rate_half, bits 15..0: block, bit j = information bit j
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 16'h0000}, {1'b0, 16'hFFFF}, {1'b1, 16'h8001},
    {1'b1, 16'hA5C3}, {1'b0, 16'h1234}, {1'b1, 16'h0001}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_bit = 1'b0, in_sob = 1'b0, rate_half = 1'b0;
  logic in_ready, out_valid, out_sys, out_par1, out_par1_keep;
  logic out_par2, out_par2_keep, out_tail;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  bit e_sys [NS], e_p1 [NS], e_k1 [NS], e_p2 [NS], e_k2 [NS], e_tl [NS];
  bit a_sys [NS], a_p1 [NS], a_k1 [NS], a_p2 [NS], a_k2 [NS], a_tl [NS];
  int a_cyc [NS];
  int a_n;

  tc_ppc_encoder #(.BLK_LEN(BK), .PERM_MUL(BP)) i_tc_ppc_encoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_sob(in_sob), .rate_half(rate_half),
    .out_valid(out_valid), .out_sys(out_sys), .out_par1(out_par1),
    .out_par1_keep(out_par1_keep), .out_par2(out_par2),
    .out_par2_keep(out_par2_keep), .out_tail(out_tail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // independent model: memory-3 recursive code, cells s1 s2 s3
  task automatic ref_block(input logic [15:0] d, input bit half);
    bit s1, s2, s3, fb, a, u;
    int ti;
    s1 = 0; s2 = 0; s3 = 0;
    for (int j = 0; j < BK; j++) begin
      u = d[j]; fb = s1 ^ s3; a = u ^ fb;
      e_sys[j] = u; e_p1[j] = a ^ s2 ^ s3;
      s3 = s2; s2 = s1; s1 = a;
      e_k1[j] = !half || (j % 2 == 0);
      e_k2[j] = !half || (j % 2 == 1);
      e_tl[j] = 0;
    end
    for (int t = 0; t < 3; t++) begin
      ti = BK + t; fb = s1 ^ s3; u = fb; a = 0;
      e_sys[ti] = u; e_p1[ti] = s2 ^ s3; e_k1[ti] = 1;
      e_p2[ti] = 0; e_k2[ti] = 0; e_tl[ti] = 1;
      s3 = s2; s2 = s1; s1 = a;
    end
    chk("R7 natural encoder ends at zero", {s1, s2, s3}, 0);
    s1 = 0; s2 = 0; s3 = 0;
    for (int j = 0; j < BK; j++) begin
      u = d[(BP * j) % BK]; fb = s1 ^ s3; a = u ^ fb;
      e_p2[j] = a ^ s2 ^ s3;
      s3 = s2; s2 = s1; s1 = a;
    end
    for (int t = 0; t < 3; t++) begin
      ti = BK + 3 + t; fb = s1 ^ s3; u = fb; a = 0;
      e_sys[ti] = u; e_p2[ti] = s2 ^ s3; e_k2[ti] = 1;
      e_p1[ti] = 0; e_k1[ti] = 0; e_tl[ti] = 1;
      s3 = s2; s2 = s1; s1 = a;
    end
    chk("R7 permuted encoder ends at zero", {s1, s2, s3}, 0);
  endtask

  // send n bits; first carries in_sob when with_sob
  task automatic send(input logic [15:0] d, input int n, input bit with_sob, input bit half);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!in_ready) begin
        in_valid = 0;
        @(negedge clk);
      end
      in_valid = 1; in_bit = d[i]; in_sob = with_sob && (i == 0); rate_half = half;
    end
    @(negedge clk);
    in_valid = 0; in_sob = 0;
  endtask

  task automatic collect();
    a_n = 0;
    for (int w = 0; w < NS + 20; w++) begin
      if (out_valid) begin
        if (a_n < NS) begin
          a_sys[a_n] = out_sys; a_p1[a_n] = out_par1; a_k1[a_n] = out_par1_keep;
          a_p2[a_n] = out_par2; a_k2[a_n] = out_par2_keep; a_tl[a_n] = out_tail;
          a_cyc[a_n] = cyc;
        end
        a_n++;
      end
      @(negedge clk);
    end
  endtask

  task automatic compare(input bit half);
    chk("R10 symbols per block", a_n, NS);
    if (a_n >= NS) begin
      chk("R10 consecutive symbols", a_cyc[NS-1] - a_cyc[0], NS - 1);
      for (int i = 0; i < NS; i++) begin
        if (i < BK) begin
          chk("R4 systematic", a_sys[i], e_sys[i]);
          chk("R5 parity natural", a_p1[i], e_p1[i]);
          chk("R6 parity permuted", a_p2[i], e_p2[i]);
          chk(half ? "R9 keep1" : "R8 keep1", a_k1[i], e_k1[i]);
          chk(half ? "R9 keep2" : "R8 keep2", a_k2[i], e_k2[i]);
          chk("R10 data flag", a_tl[i], 0);
        end else begin
          chk("R7 tail fields",
              {a_sys[i], a_p1[i], a_k1[i], a_p2[i], a_k2[i], a_tl[i]},
              {e_sys[i], e_p1[i], e_k1[i], e_p2[i], e_k2[i], e_tl[i]});
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", out_valid, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 in_ready after reset", in_ready, 1);

    // table of blocks
    for (int v = 0; v < NV; v++) begin
      ref_block(VEC[v][15:0], VEC[v][16]);
      send(VEC[v][15:0], BK, 1, VEC[v][16]);
      if (v == 0) chk("R2 ready drops after K bits", in_ready, 0);
      collect();
      compare(VEC[v][16]);
      chk("R2 ready back after block", in_ready, 1);
    end

    // R3: bits without start flag while idle are ignored
    send(16'hFFFF, 5, 0, 1);
    ref_block(16'h3C69, 0);
    send(16'h3C69, BK, 1, 0);
    collect();
    compare(0);

    // R3: start flag mid-load restarts the block
    send(16'hFFFF, 7, 1, 0);
    ref_block(16'h0F0F, 1);
    send(16'h0F0F, BK, 1, 1);
    collect();
    compare(1);

    // R3 / R10: nothing emitted from a partial block
    send(16'h5555, 4, 1, 0);
    collect();
    chk("R3 partial block gives no symbols", a_n, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule